// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives a three-phase inverter bridge. A 16-bit up/down counter forms a symmetric triangle carrier, and each phase compares the carrier with its own duty value. The result drives a high-side and a low-side gate output. A single programmable dead time is added automatically at every switch of a pair, so the two gates of one leg are never on together and always pass through a both-off gap.

Duty values, the carrier period and the converter trigger delay are sampled at defined carrier points only. A new setting written in mid-cycle therefore never cuts a pulse short. Any duty from fully off to fully on is accepted. Crest and trough interrupt requests can be thinned out by a skip count. A one-cycle converter start pulse is placed a programmable number of clocks after each trough, and it is clipped to the crest.

Top module: `tri_pwm_gen`

## Requirements
- R1: The `carrier` output counts 0,1,…,P,P-1,…,1,0,1,… with one step per clock, so a full carrier cycle is 2P clocks. P is the `period` value sampled whenever `carrier` is 0. P must be at least 2.
- R2: While reset is held, all six gate outputs are low. A gate pair `hi[i]`/`lo[i]` is never high in the same cycle.
- R3: For a duty D with 0 < D < P and 2D-1 > T, where T is `deadtime`, `hi[i]` stays high for 2D-1-T clocks per carrier cycle and `lo[i]` for 2P-2D+1-T clocks. Both outputs of the pair are low for exactly T clocks at each switch.
- R4: A duty of 0 keeps `hi[i]` low and `lo[i]` high for the whole carrier cycle. A duty of P or more keeps `hi[i]` high and `lo[i]` low. No dead-time gap appears in either case.
- R5: Duty values are taken only when `carrier` is 0 or P. A duty written during the rising half leaves the current pulse unchanged. For a duty D, `hi[i]` falls on the sample where `carrier` reads D+2. The new duty governs the next pulse.
- R6: A crest is the cycle where `carrier` equals P. `crest_irq` pulses one clock after a crest, but only on every (S+1)-th crest, where S is `skip` (0 to 7).
- R7: A trough is the cycle where `carrier` returns to 0. `trough_irq` pulses one clock after a trough, on every (S+1)-th trough. Its skip count is separate from the crest count.
- R8: `adc_start` is a one-clock pulse. It goes high min(d,P)+1 clocks after the trough sample, where d is the converter delay. A delay longer than the half period fires at the crest.
- R9: The converter delay is sampled at the trough. A change to `adc_delay` later in the same half cycle has no effect until the next trough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 16 | Carrier peak value P |
| deadtime | input | 16 | Dead time T in clocks |
| duty | input | 3x16 | Duty compare value per phase |
| skip | input | 3 | Interrupt skip count S |
| adc_delay | input | 16 | Converter trigger delay d in clocks after the trough |
| carrier | output | 16 | Current triangle counter value |
| hi | output | 3 | High-side gate per phase |
| lo | output | 3 | Low-side gate per phase |
| crest_irq | output | 1 | Crest interrupt request pulse |
| trough_irq | output | 1 | Trough interrupt request pulse |
| adc_start | output | 1 | Converter start pulse |

## Verification
The assertions check, on every cycle, the rules that hold locally. Each carrier step is one count. A pair never overlaps. With a nonzero dead time, a high-side gate never rises directly out of an active low side. Interrupt pulses sit one clock after a crest or trough. The converter pulse is never longer than one clock. Behaviour measured across whole carrier cycles can only be shown by the bench scenarios: pulse widths against duty, exact gap lengths, timing of shadow loads, the skip ratios and the delay clipping.

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen #(
  parameter int CW  = 16,
  parameter int PH  = 3,
  parameter int SKW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         period,
  input  logic [CW-1:0]         deadtime,
  input  logic [PH-1:0][CW-1:0] duty,
  input  logic [SKW-1:0]        skip,
  input  logic [CW-1:0]         adc_delay,
  output logic [CW-1:0]         carrier,
  output logic [PH-1:0]         hi,
  output logic [PH-1:0]         lo,
  output logic                  crest_irq,
  output logic                  trough_irq,
  output logic                  adc_start
);

  localparam logic [CW-1:0] AGE_MAX = '1;

  logic [CW-1:0]         cnt, per_q, dly_q;
  logic                  up;
  logic [PH-1:0][CW-1:0] duty_q;
  logic [SKW-1:0]        crest_sk, trough_sk;

  wire            at_zero = (cnt == '0);
  wire [CW-1:0]   per_use = at_zero ? period : per_q;
  wire [CW-1:0]   dly_use = at_zero ? adc_delay : dly_q;
  wire [CW-1:0]   dly_eff = (dly_use > per_use) ? per_use : dly_use;
  wire            crest   = up && (per_use != '0) && (cnt >= per_use);
  wire            trough  = !up && at_zero;
  wire            load    = at_zero || crest;

  assign carrier = cnt;

  // triangle carrier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      up    <= 1'b1;
      per_q <= '0;
      dly_q <= '0;
    end else begin
      per_q <= per_use;
      dly_q <= dly_use;
      if (per_use == '0) begin
        cnt <= '0;
        up  <= 1'b1;
      end else if (up) begin
        if (cnt >= per_use) begin
          cnt <= cnt - 1'b1;
          up  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (at_zero) begin
        cnt <= {{(CW-1){1'b0}}, 1'b1};
        up  <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // per-phase compare and dead time
  for (genvar i = 0; i < PH; i++) begin : g_phase
    wire [CW-1:0] d_use = load ? duty[i] : duty_q[i];
    wire          raw   = (d_use >= per_use) || (cnt < d_use);
    logic         raw_q, hi_q, lo_q;
    logic [CW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_q[i] <= '0;
        raw_q     <= 1'b0;
        age       <= '0;
        hi_q      <= 1'b0;
        lo_q      <= 1'b0;
      end else begin
        duty_q[i] <= d_use;
        raw_q     <= raw;
        if (raw != raw_q)        age <= '0;
        else if (age != AGE_MAX) age <= age + 1'b1;
        hi_q <= raw_q && (age >= deadtime);
        lo_q <= !raw_q && (age >= deadtime);
      end
    end

    assign hi[i] = hi_q;
    assign lo[i] = lo_q;
  end

  // interrupt thinning and converter trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crest_sk   <= '0;
      trough_sk  <= '0;
      crest_irq  <= 1'b0;
      trough_irq <= 1'b0;
      adc_start  <= 1'b0;
    end else begin
      crest_irq  <= 1'b0;
      trough_irq <= 1'b0;
      if (crest) begin
        if (crest_sk >= skip) begin
          crest_sk  <= '0;
          crest_irq <= 1'b1;
        end else begin
          crest_sk <= crest_sk + 1'b1;
        end
      end
      if (trough) begin
        if (trough_sk >= skip) begin
          trough_sk  <= '0;
          trough_irq <= 1'b1;
        end else begin
          trough_sk <= trough_sk + 1'b1;
        end
      end
      adc_start <= (per_use != '0) && (cnt == dly_eff) && (up || at_zero);
    end
  end

endmodule

// File: rtl/tri_pwm_gen_chk.sv
module tri_pwm_gen_chk #(
  parameter int CW = 16,
  parameter int PH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] deadtime,
  input logic [CW-1:0] carrier,
  input logic [PH-1:0] hi,
  input logic [PH-1:0] lo,
  input logic          crest_irq,
  input logic          trough_irq,
  input logic          adc_start
);

  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (carrier == $past(carrier) + 16'd1) || (carrier + 16'd1 == $past(carrier))
             || (carrier == '0 && $past(carrier) == '0));

  a_r2_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (hi == '0 && lo == '0));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (hi & lo) == '0);

  a_r3_gap_before_high: assert property (@(posedge clk) disable iff (!rst_n)
    (deadtime != '0) |-> ((hi & ~$past(hi) & $past(lo)) == '0));

  a_r6_crest_timing: assert property (@(posedge clk) disable iff (!rst_n)
    crest_irq |-> ($past(carrier) == carrier + 16'd1));

  a_r7_trough_timing: assert property (@(posedge clk) disable iff (!rst_n)
    trough_irq |-> (carrier == 16'd1 && $past(carrier) == '0));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

endmodule

bind tri_pwm_gen tri_pwm_gen_chk u_chk (.*);

// File: tb/tri_pwm_gen_test.sv
`timescale 1ns/1ps
module tri_pwm_gen_test;
  localparam int P = 40;
  localparam int T = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      period = 16'(P);
  logic [15:0]      deadtime = 16'(T);
  logic [2:0][15:0] duty;
  logic [2:0]       skip = '0;
  logic [15:0]      adc_delay = 16'd5;
  logic [15:0]      carrier;
  logic [2:0]       hi, lo;
  logic             crest_irq, trough_irq, adc_start;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tri_pwm_gen uut (
    .clk(clk), .rst_n(rst_n), .period(period), .deadtime(deadtime), .duty(duty),
    .skip(skip), .adc_delay(adc_delay), .carrier(carrier), .hi(hi), .lo(lo),
    .crest_irq(crest_irq), .trough_irq(trough_irq), .adc_start(adc_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  function automatic bit gate(input int idx, input bit low_side);
    return low_side ? lo[idx] : hi[idx];
  endfunction

  task automatic wait_trough();
    do @(negedge clk); while (carrier != 16'd0);
  endtask

  task automatic run_len(input int idx, input bit low_side, output int n);
    while (gate(idx, low_side) != 1'b0) @(negedge clk);
    while (gate(idx, low_side) != 1'b1) @(negedge clk);
    n = 0;
    while (gate(idx, low_side) == 1'b1) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(hi == 3'b000 && lo == 3'b000, "R2 gates low in reset", int'({hi, lo}), 0);
    check(carrier == 16'd0, "R1 carrier zero in reset", int'(carrier), 0);
    check(!crest_irq && !trough_irq && !adc_start, "R6 R7 R8 pulses low in reset",
          int'({crest_irq, trough_irq, adc_start}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_carrier();
    int n = 0, mx = 0, mn = 1 << 20;
    do @(negedge clk); while (carrier != 16'(P));
    do begin
      @(negedge clk);
      n++;
      if (int'(carrier) > mx) mx = int'(carrier);
      if (int'(carrier) < mn) mn = int'(carrier);
    end while (carrier != 16'(P));
    check(n == 2 * P, "R1 carrier cycle length", n, 2 * P);
    check(mx == P, "R1 carrier peak", mx, P);
    check(mn == 0, "R1 carrier floor", mn, 0);
  endtask

  task automatic t_duty_dead();
    int dv[3] = '{10, 20, 30};
    int n, g, ov;
    repeat (3 * 2 * P) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      run_len(i, 1'b0, n);
      check(n == 2 * dv[i] - 1 - T, "R3 high-side width", n, 2 * dv[i] - 1 - T);
      run_len(i, 1'b1, n);
      check(n == 2 * P - 2 * dv[i] + 1 - T, "R3 low-side width", n, 2 * P - 2 * dv[i] + 1 - T);
      while (hi[i] != 1'b1) @(negedge clk);
      while (hi[i] != 1'b0) @(negedge clk);
      g = 0;
      while (!hi[i] && !lo[i]) begin g++; @(negedge clk); end
      check(g == T, "R3 gap high to low", g, T);
      while (lo[i] != 1'b0) @(negedge clk);
      g = 0;
      while (!hi[i] && !lo[i]) begin g++; @(negedge clk); end
      check(g == T, "R3 gap low to high", g, T);
    end
    ov = 0;
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      if ((hi & lo) != 3'b000) ov++;
    end
    check(ov == 0, "R2 no pair overlap", ov, 0);
  endtask

  task automatic t_extremes();
    int bad0 = 0, bad1 = 0, bad2 = 0;
    duty[0] = 16'd0;
    duty[1] = 16'(P);
    duty[2] = 16'd50;
    repeat (3 * 2 * P) @(negedge clk);
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      if (!(hi[0] == 1'b0 && lo[0] == 1'b1)) bad0++;
      if (!(hi[1] == 1'b1 && lo[1] == 1'b0)) bad1++;
      if (!(hi[2] == 1'b1 && lo[2] == 1'b0)) bad2++;
    end
    check(bad0 == 0, "R4 zero duty holds low side", bad0, 0);
    check(bad1 == 0, "R4 duty equal to period holds high side", bad1, 0);
    check(bad2 == 0, "R4 duty above period holds high side", bad2, 0);
    duty[0] = 16'd10;
    duty[1] = 16'd20;
    duty[2] = 16'd30;
    repeat (3 * 2 * P) @(negedge clk);
  endtask

  task automatic t_buffer();
    int n, c;
    wait_trough();
    while (carrier != 16'd3) @(negedge clk);
    duty[0] = 16'd25;
    while (hi[0] != 1'b0) @(negedge clk);
    c = int'(carrier);
    check(c == 12, "R5 pulse ends at old duty", c, 12);
    run_len(0, 1'b0, n);
    check(n == 2 * 25 - 1 - T, "R5 new duty on next pulse", n, 2 * 25 - 1 - T);
    duty[0] = 16'd10;
    repeat (2 * 2 * P) @(negedge clk);
  endtask

  task automatic count_irqs(input int cycles, output int nc, output int nt);
    nc = 0;
    nt = 0;
    wait_trough();
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (crest_irq) nc++;
      if (trough_irq) nt++;
    end
  endtask

  task automatic t_skip();
    int nc, nt;
    skip = 3'd2;
    count_irqs(9 * 2 * P, nc, nt);
    check(nc == 3, "R6 crest every third event", nc, 3);
    check(nt == 3, "R7 trough every third event", nt, 3);
    skip = 3'd0;
    count_irqs(4 * 2 * P, nc, nt);
    check(nc == 4, "R6 crest every event", nc, 4);
    check(nt == 4, "R7 trough every event", nt, 4);
  endtask

  task automatic adc_once(input int d, input string req);
    int n = 0, exp;
    adc_delay = 16'(d);
    repeat (2 * 2 * P) @(negedge clk);
    wait_trough();
    do begin @(negedge clk); n++; end while (!adc_start && n < 4 * P);
    exp = ((d > P) ? P : d) + 1;
    check(n == exp, req, n, exp);
    @(negedge clk);
    check(!adc_start, "R8 pulse one clock", int'(adc_start), 0);
  endtask

  task automatic t_adc();
    int n = 0;
    adc_once(7, "R8 delay after trough");
    adc_once(0, "R8 zero delay");
    adc_once(100, "R8 delay clipped to crest");
    adc_delay = 16'd7;
    repeat (2 * 2 * P) @(negedge clk);
    wait_trough();
    @(negedge clk);
    n = 1;
    adc_delay = 16'd20;
    do begin @(negedge clk); n++; end while (!adc_start && n < 4 * P);
    check(n == 8, "R9 delay held from trough", n, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++;
    fails++;
    summary();
    $finish;
  end

  initial begin
    duty[0] = 16'd10;
    duty[1] = 16'd20;
    duty[2] = 16'd30;
    t_reset();
    t_carrier();
    t_duty_dead();
    t_extremes();
    t_buffer();
    t_skip();
    t_adc();
    summary();
    $finish;
  end
endmodule